// File: doc/BRIEF.md
# Quad-Phase Oversampling Bit Recovery

This block recovers the bits of a serial line that carries no clock. Four clocks of the same frequency, a quarter period apart, each sample the line once per period. With a data rate close to the clock rate, every unit interval gets about four samples. The four samples are moved into the phase-0 clock domain as one group per cycle. Data edges are found there, and a 2-bit selector names the sample position in the group that is treated as the bit centre.

No bit is trusted until the line shows its first rising transition. That transition places the selector about half a unit interval after the edge and arms the block. From then on the selector follows the edges one step at a time. A frequency offset between transmitter and receiver makes the selector drift, and at some point it wraps around the group. When it wraps toward earlier samples, the cycle holds two bits. When it wraps toward later samples, the bit has already been delivered and the cycle holds none. Downstream logic gets the bits together with a count and packs them into words.

Top module: `quadPhaseFollower`

## Requirements
- R1: With the line running at exactly the sampling clock rate, the recovered bit stream equals the transmitted stream, bit for bit.
- R2: A synchronous reset, sampled on the phase-0 clock, drives `locked` low and `bitCnt` to 0, including when it arrives in the middle of a stream.
- R3: Before the first 0-to-1 transition after reset, `locked` stays low and `bitCnt` stays 0. A line held high and a falling transition both leave the block unlocked.
- R4: The first recovered bit is the 1 that follows the first rising transition. Every later bit follows in transmitted order.
- R5: `bitCnt` takes only the values 0, 1 and 2, never 3. With 1, the bit is on `bitsOut[0]`. With 2, `bitsOut[1]` is the earlier bit and `bitsOut[0]` the later one.
- R6: While locked, the selector moves by at most one sample position per cycle. With a 3% rate offset in either direction the stream is still recovered without loss or duplication.
- R7: When the line runs 0.4% slower than the clock, some locked cycles emit zero bits, no cycle emits two, and the stream is recovered intact.
- R8: When the line runs 0.4% faster than the clock, some cycles emit two bits, no locked cycle emits zero, and the stream is recovered intact.
- R9: At exactly matched rate, every cycle after the first recovered bit emits exactly one bit.
- R10: Once set, `locked` stays high until the next reset, even across long runs without transitions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkPh0 | input | 1 | Sampling clock at 0 degrees; also the system clock of the block |
| clkPh90 | input | 1 | Sampling clock delayed by a quarter period |
| clkPh180 | input | 1 | Sampling clock delayed by half a period |
| clkPh270 | input | 1 | Sampling clock delayed by three quarters of a period |
| rst | input | 1 | Synchronous reset, active high, on clkPh0 |
| serialIn | input | 1 | Serial data line |
| bitsOut | output | 2 | Recovered bits; bit 0 always used, bit 1 only in two-bit cycles |
| bitCnt | output | 2 | Number of valid bits this cycle: 0, 1 or 2 |
| locked | output | 1 | High once the first rising transition has set the sampling point |

## Verification
In a cycle where the selector steps across the group boundary, a step and a change in the bit count fall together. The emission of that cycle must then skip a sample or add one, and must not simply repeat the normal single bit. The bench provokes this by sending long pseudo-random streams at 0.4% and 3% slower and faster rates, which forces several wraps in each direction. It judges the outcome by comparing the concatenated recovered stream to the sent one, so a lost or doubled bit at a wrap shows up as a misalignment. It also checks that zero-bit and two-bit cycles occur only in the direction the offset calls for.

// File: rtl/qpf_pkg.sv
package qpf_pkg;
  // number of sampling phases per clock period
  localparam int PHASES = 4;
  localparam int SEL_W  = $clog2(PHASES);
  localparam int CNT_W  = 2;

  typedef logic [SEL_W-1:0] sel_t;

  // how many recovered bits a cycle carries
  typedef enum logic [CNT_W-1:0] {
    EMIT_NONE = 2'd0,
    EMIT_ONE  = 2'd1,
    EMIT_TWO  = 2'd2
  } emit_e;

  // strobes from control to datapath
  typedef struct packed {
    sel_t  pick;   // 0 = newest sample of the group
    emit_e emit;
  } strobe_t;
endpackage

// File: rtl/qpfSampler.sv
module qpfSampler #(
  parameter int PHASES = qpf_pkg::PHASES
) (
  input  logic [PHASES-1:0] phClk,
  input  logic              serialIn,
  output logic [PHASES-1:0] newerGrp
);
  logic [PHASES-1:0] tap;

  // one capture flop per sampling phase
  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    logic capt;
    always_ff @(posedge phClk[g]) capt <= serialIn;
    assign tap[g] = capt;
  end

  // move the group into the phase-0 domain; index 0 holds the newest sample
  always_ff @(posedge phClk[0]) begin
    for (int i = 0; i < PHASES; i++) newerGrp[i] <= tap[PHASES-1-i];
  end
endmodule

// File: rtl/qpfDatapath.sv
module qpfDatapath import qpf_pkg::*; #(
  parameter int PHASES = qpf_pkg::PHASES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] newerGrp,
  input  strobe_t           strb,
  output logic              olderNewest,
  output logic [1:0]        bitsOut,
  output logic [1:0]        bitCnt
);
  logic [PHASES-1:0] olderGrp;

  always_ff @(posedge clk) olderGrp <= newerGrp;

  assign olderNewest = olderGrp[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bitsOut <= '0;
      bitCnt  <= '0;
    end else begin
      bitCnt     <= strb.emit;
      bitsOut[0] <= olderGrp[strb.pick];
      bitsOut[1] <= (strb.emit == EMIT_TWO) ? olderGrp[PHASES-1] : 1'b0;
    end
  end
endmodule

// File: rtl/qpfControl.sv
module qpfControl import qpf_pkg::*; #(
  parameter int PHASES = qpf_pkg::PHASES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] newerGrp,
  input  logic              olderNewest,
  output strobe_t           strb,
  output logic              locked
);
  localparam sel_t HALF = sel_t'(PHASES / 2);
  localparam sel_t TOP  = sel_t'(PHASES - 1);
  localparam sel_t ONE  = sel_t'(1);

  logic [PHASES:0] chain;
  logic  edgeSeen, riseSeen;
  sel_t  edgeIdx, riseIdx;
  sel_t  edgeTarget, riseTarget, step, nextPick;
  emit_e nextEmit;
  logic  nextLocked;

  // chronological chain: previous newest sample, then the newer group
  assign chain = {olderNewest, newerGrp};

  // transition search; the earliest transition in time wins
  always_comb begin
    edgeSeen = 1'b0;
    riseSeen = 1'b0;
    edgeIdx  = '0;
    riseIdx  = '0;
    for (int j = 0; j < PHASES; j++) begin
      if (chain[j] != chain[j+1]) begin
        edgeSeen = 1'b1;
        edgeIdx  = sel_t'(j);
      end
      if (chain[j] && !chain[j+1]) begin
        riseSeen = 1'b1;
        riseIdx  = sel_t'(j);
      end
    end
  end

  // centre lies half a unit interval after the first sample of the new bit
  assign edgeTarget = edgeIdx + HALF;
  assign riseTarget = riseIdx + HALF;
  assign step       = edgeTarget - strb.pick;

  always_comb begin
    nextPick   = strb.pick;
    nextLocked = locked;
    nextEmit   = EMIT_NONE;
    if (!locked) begin
      if (riseSeen) begin
        nextLocked = 1'b1;
        nextPick   = riseTarget;
        // centre falls inside this group only if the edge is early enough
        if (riseIdx >= HALF) nextEmit = EMIT_ONE;
      end
    end else begin
      if (edgeSeen && step == ONE)      nextPick = strb.pick + ONE;
      else if (edgeSeen && step == TOP) nextPick = strb.pick - ONE;
      if (strb.pick == TOP && nextPick == '0)      nextEmit = EMIT_TWO;
      else if (strb.pick == '0 && nextPick == TOP) nextEmit = EMIT_NONE;
      else                                         nextEmit = EMIT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb   <= '{pick: '0, emit: EMIT_NONE};
      locked <= 1'b0;
    end else begin
      strb   <= '{pick: nextPick, emit: nextEmit};
      locked <= nextLocked;
    end
  end
endmodule

// File: rtl/quadPhaseFollower.sv
module quadPhaseFollower import qpf_pkg::*; (
  input  logic       clkPh0,
  input  logic       clkPh90,
  input  logic       clkPh180,
  input  logic       clkPh270,
  input  logic       rst,
  input  logic       serialIn,
  output logic [1:0] bitsOut,
  output logic [1:0] bitCnt,
  output logic       locked
);
  logic [PHASES-1:0] newerGrp;
  logic              olderNewest;
  strobe_t           ctrlStrb;

  qpfSampler #(.PHASES(PHASES)) sampler_i (
    .phClk    ({clkPh270, clkPh180, clkPh90, clkPh0}),
    .serialIn (serialIn),
    .newerGrp (newerGrp)
  );

  qpfControl #(.PHASES(PHASES)) control_i (
    .clk         (clkPh0),
    .rst         (rst),
    .newerGrp    (newerGrp),
    .olderNewest (olderNewest),
    .strb        (ctrlStrb),
    .locked      (locked)
  );

  qpfDatapath #(.PHASES(PHASES)) datapath_i (
    .clk         (clkPh0),
    .rst         (rst),
    .newerGrp    (newerGrp),
    .strb        (ctrlStrb),
    .olderNewest (olderNewest),
    .bitsOut     (bitsOut),
    .bitCnt      (bitCnt)
  );
endmodule

// File: rtl/qpfChecker.sv
module qpfChecker import qpf_pkg::*; (
  input logic       clk,
  input logic       rst,
  input logic       locked,
  input logic [1:0] bitCnt,
  input strobe_t    strb
);
  localparam sel_t TOP = sel_t'(PHASES - 1);

  sel_t       prevPick;
  logic       prevLocked;
  logic [1:0] prevEmit;
  sel_t       pickDelta;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevPick   <= '0;
      prevLocked <= 1'b0;
      prevEmit   <= '0;
    end else begin
      prevPick   <= strb.pick;
      prevLocked <= locked;
      prevEmit   <= strb.emit;
    end
  end

  assign pickDelta = strb.pick - prevPick;

  p_cnt_legal_r5: assert property (@(posedge clk) disable iff (rst)
    bitCnt != 2'd3);

  p_cnt_follows_r5: assert property (@(posedge clk) disable iff (rst)
    bitCnt == prevEmit);

  p_silent_unlocked_r3: assert property (@(posedge clk) disable iff (rst)
    !locked |-> bitCnt == 2'd0);

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  p_step_limit_r6: assert property (@(posedge clk) disable iff (rst)
    (locked && prevLocked) |-> (pickDelta != sel_t'(PHASES / 2)));

  p_wrap_fast_r8: assert property (@(posedge clk) disable iff (rst)
    (locked && prevLocked && prevPick == TOP && strb.pick == '0) |-> strb.emit == EMIT_TWO);

  p_wrap_slow_r7: assert property (@(posedge clk) disable iff (rst)
    (locked && prevLocked && prevPick == '0 && strb.pick == TOP) |-> strb.emit == EMIT_NONE);
endmodule

bind quadPhaseFollower qpfChecker chk_i (
  .clk    (clkPh0),
  .rst    (rst),
  .locked (locked),
  .bitCnt (bitCnt),
  .strb   (ctrlStrb)
);

// File: tb/quadPhaseFollower_tb_top.sv
`timescale 1ps/1ps
module quadPhaseFollower_tb_top;
  localparam int HALF_PS  = 2000;   // 250 MHz
  localparam int EDGE_OFS = 503;    // line edges never coincide with a clock edge
  localparam int RX_MAX   = 2048;
  localparam int TX_MAX   = 1200;

  logic clkPh0 = 0, clkPh90 = 0, clkPh180 = 0, clkPh270 = 0;
  logic rst = 1, serialIn = 0;
  logic [1:0] bitsOut, bitCnt;
  logic locked;

  initial forever #HALF_PS clkPh0 = ~clkPh0;
  initial begin #1000; forever #HALF_PS clkPh90  = ~clkPh90;  end
  initial begin #2000; forever #HALF_PS clkPh180 = ~clkPh180; end
  initial begin #3000; forever #HALF_PS clkPh270 = ~clkPh270; end

  quadPhaseFollower dut_i (
    .clkPh0(clkPh0), .clkPh90(clkPh90), .clkPh180(clkPh180), .clkPh270(clkPh270),
    .rst(rst), .serialIn(serialIn), .bitsOut(bitsOut), .bitCnt(bitCnt), .locked(locked)
  );

  int nCompared = 0, nMismatched = 0, cycles = 0;
  bit done = 0;

  logic rxBits [RX_MAX];
  logic txBits [TX_MAX];
  int   rxLen, zeroCyc, twoCyc, badCnt;
  bit   monOn, seenBit;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input string expTxt);
    nCompared++;
    if (!ok) begin
      nMismatched++;
      $display("FAIL %s %s: actual %0d expected %s", req, what, act, expTxt);
    end
  endtask

  // output monitor, sampled on the falling edge
  always @(negedge clkPh0) begin
    if (monOn) begin
      if (bitCnt == 2'd3) badCnt++;
      if (bitCnt == 2'd2) begin
        if (rxLen < RX_MAX) rxBits[rxLen] = bitsOut[1];
        rxLen++;
        if (rxLen < RX_MAX) rxBits[rxLen] = bitsOut[0];
        rxLen++;
        twoCyc++;
      end else if (bitCnt == 2'd1) begin
        if (rxLen < RX_MAX) rxBits[rxLen] = bitsOut[0];
        rxLen++;
      end else if (seenBit) begin
        zeroCyc++;
      end
      if (bitCnt != 2'd0) seenBit = 1;
    end
  end

  always @(posedge clkPh0) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: actual %0d expected fewer cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

  task automatic clearMon();
    rxLen = 0; zeroCyc = 0; twoCyc = 0; badCnt = 0; seenBit = 0; monOn = 1;
  endtask

  task automatic doReset();
    @(negedge clkPh0); rst = 1;
    repeat (6) @(posedge clkPh0);
    @(negedge clkPh0); rst = 0;
  endtask

  task automatic lineSet(input logic v);
    @(posedge clkPh0); #EDGE_OFS; serialIn = v;
  endtask

  task automatic fillTx(input int n, input logic [6:0] seed);
    logic [6:0] s = seed;
    for (int i = 0; i < n; i++) begin
      txBits[i] = s[0];
      s = {s[5:0], s[6] ^ s[5]};
    end
    txBits[0] = 1'b1;
  endtask

  // sends a stream and compares the recovered bits
  task automatic runStream(input string req, input int uiPs, input int nBits,
                           input logic [6:0] seed);
    int mism = 0, firstBad = -1;
    fillTx(nBits, seed);
    serialIn = 0;
    doReset();
    clearMon();
    lineSet(1'b0);
    repeat (12) #uiPs;
    for (int i = 0; i < nBits; i++) begin
      serialIn = txBits[i];
      #uiPs;
    end
    serialIn = 0;
    repeat (12) #uiPs;
    repeat (6) @(posedge clkPh0);
    @(negedge clkPh0);
    monOn = 0;
    for (int i = 0; i < nBits; i++) begin
      if (rxBits[i] !== txBits[i]) begin
        mism++;
        if (firstBad < 0) firstBad = i;
      end
    end
    check(rxLen >= nBits, req, "recovered length", rxLen, $sformatf(">= %0d", nBits));
    check(mism == 0, req, $sformatf("stream mismatches (first at %0d)", firstBad), mism, "0");
    check(rxBits[0] === 1'b1, "R4", "first recovered bit", int'(rxBits[0]), "1");
    check(badCnt == 0, "R5", "cycles with count 3", badCnt, "0");
  endtask

  task automatic testResetState();
    serialIn = 0;
    doReset();
    check(locked == 1'b0, "R2", "locked after reset", int'(locked), "0");
    check(bitCnt == 2'd0, "R2", "bitCnt after reset", int'(bitCnt), "0");
  endtask

  task automatic testLockRules();
    clearMon();
    lineSet(1'b1);
    doReset();
    repeat (20) @(posedge clkPh0);
    @(negedge clkPh0);
    check(locked == 1'b0, "R3", "locked with line held high", int'(locked), "0");
    check(rxLen == 0, "R3", "bits with line held high", rxLen, "0");
    lineSet(1'b0);
    repeat (20) @(posedge clkPh0);
    @(negedge clkPh0);
    check(locked == 1'b0, "R3", "locked after falling edge", int'(locked), "0");
    check(rxLen == 0, "R3", "bits after falling edge", rxLen, "0");
    lineSet(1'b1);
    repeat (10) @(posedge clkPh0);
    @(negedge clkPh0);
    check(locked == 1'b1, "R3", "locked after rising edge", int'(locked), "1");
    repeat (40) @(posedge clkPh0);
    @(negedge clkPh0);
    check(locked == 1'b1, "R10", "locked after long idle", int'(locked), "1");
    check(rxLen > 0, "R10", "bits flowing while idle", rxLen, "> 0");
    rst = 1;
    @(posedge clkPh0);
    @(negedge clkPh0);
    check(locked == 1'b0, "R2", "locked after mid-stream reset", int'(locked), "0");
    check(bitCnt == 2'd0, "R2", "bitCnt after mid-stream reset", int'(bitCnt), "0");
    rst = 0;
    monOn = 0;
  endtask

  task automatic testMatchedRate();
    runStream("R1", 4000, 800, 7'h5b);
    check(zeroCyc == 0, "R9", "zero-bit cycles at matched rate", zeroCyc, "0");
    check(twoCyc == 0, "R9", "two-bit cycles at matched rate", twoCyc, "0");
  endtask

  task automatic testSlowLine();
    runStream("R7", 4016, 1000, 7'h23);
    check(zeroCyc > 0, "R7", "zero-bit cycles on slow line", zeroCyc, "> 0");
    check(twoCyc == 0, "R7", "two-bit cycles on slow line", twoCyc, "0");
  endtask

  task automatic testFastLine();
    runStream("R8", 3984, 1000, 7'h41);
    check(twoCyc > 0, "R8", "two-bit cycles on fast line", twoCyc, "> 0");
    check(zeroCyc == 0, "R8", "zero-bit cycles on fast line", zeroCyc, "0");
  endtask

  task automatic testLargeOffset();
    runStream("R6", 4120, 600, 7'h19);
    check(zeroCyc > 0, "R6", "zero-bit cycles at 3% slow", zeroCyc, "> 0");
    runStream("R6", 3880, 600, 7'h6e);
    check(twoCyc > 0, "R6", "two-bit cycles at 3% fast", twoCyc, "> 0");
  endtask

  initial begin
    monOn = 0;
    testResetState();
    testLockRules();
    testMatchedRate();
    testSlowLine();
    testFastLine();
    testLargeOffset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end
endmodule